// File: doc/BRIEF.md
# Interrupt source configuration and trigger unit

This block holds the per-source state of a multiprocessor interrupt controller. For every interrupt source it keeps a configuration word and a destination word. The configuration word holds a vector, a priority, a mask, a sense bit, a polarity bit and a read-only activity bit. The destination word holds one bit per CPU. The block samples the raw interrupt lines and keeps one pending flag per source. Each CPU port can acknowledge a source by index, and the block updates the pending flag and, for inter-processor sources, the destination word.

Each source index belongs to one of three classes, and the class is fixed by parameters. The class decides which configuration bits software can change and whether the source is level-triggered or edge-triggered. Normal sources take their trigger mode from the stored sense bit. Internal sources are always level-triggered and show no sense bit. Timer and inter-processor sources are always edge-triggered and show neither sense nor polarity. Priority arbitration and the CPU interrupt outputs belong to a neighbouring block, which reads `pending_o` and `level_o`.

Top module: `isrc_bank`

## Requirements
- R1: With the default parameters, indices 0 to 15 are normal sources, 16 to 23 are internal sources, and 24 to 31 are special sources: 24 to 27 are timers and 28 to 31 are inter-processor sources. `level_o[s]` is 1 when source s is level-triggered and 0 when it is edge-triggered.
- R2: The configuration word has the vector in bits 7:0, the priority in bits 11:8, sense in bit 12, polarity in bit 13, activity in bit 14 and mask in bit 15. A write with `reg_sel`=0 changes only the fields that are writable for the source's class. Activity and all other bits ignore written data, and the unused bits read as 0.
- R3: For a normal source, a sense bit of 1 makes the source level-triggered and a sense bit of 0 makes it edge-triggered. The new mode is visible on `level_o` right after the write.
- R4: An internal source always reads its sense bit as 0 and is always level-triggered.
- R5: A special source always reads its sense and polarity bits as 0 and is always edge-triggered.
- R6: The polarity bit reads back as written and does not invert how the input line is sampled.
- R7: While reset is active, each configuration word takes the value of `RST_CFG` (default 0x8000) filtered by its class, and each internal source has its polarity bit forced to 1. The defaults read back 0x8000 for normal and special sources and 0xA000 for internal sources. Each destination word resets to `RST_DEST` (default 1).
- R8: For a level-triggered source, `pending_o` equals the input line as it was one clock earlier.
- R9: For an edge-triggered source, a rising edge on the input sets `pending_o` one clock later. The flag then stays set whatever the input does, until an acknowledge clears it.
- R10: Acknowledging an edge-triggered source that is not inter-processor clears its pending flag on the next clock. The activity bit reads as 1 exactly when the source is pending and its mask bit is 0.
- R11: Acknowledging a level-triggered source leaves its pending flag unchanged.
- R12: Acknowledging an inter-processor source clears the acknowledging CPU's destination bit. If other destination bits remain set, the pending flag is raised again, so it stays 1. Otherwise the flag clears.
- R13: The destination word occupies bits 3:0 (one bit per CPU) and is written and read with `reg_sel`=1. Its unused bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the configuration word, 1 selects the destination word |
| reg_idx | input | IDX_W (5) | Source index for the read and the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read of the selected word |
| irq_in | input | NUM_SRC (32) | Raw interrupt lines, synchronous to clk |
| ack_valid | input | NUM_CPU (4) | Acknowledge strobe, one per CPU |
| ack_idx | input | NUM_CPU*IDX_W (20) | Acknowledged source index for each CPU, CPU c in bits c*IDX_W and up |
| pending_o | output | NUM_SRC (32) | Pending flag per source |
| level_o | output | NUM_SRC (32) | Trigger mode per source, 1 means level-triggered |

## Verification
The assertions assume that the interrupt lines are already synchronous to the clock and stay low while reset is active. They also assume that every acknowledge index names an existing source. The edge checks compare against the registered previous value of the line, so a line that is high when reset ends would count as an edge. To stay within these assumptions, the stimulus changes every input on the falling clock edge, holds every line low through reset, and acknowledges only indices below the source count.

// File: rtl/isrc_pkg.sv
package isrc_pkg;

  typedef enum logic [1:0] {
    CLS_NORMAL   = 2'd0,
    CLS_INTERNAL = 2'd1,
    CLS_SPECIAL  = 2'd2
  } src_class_e;

  localparam int CFG_W     = 32;
  localparam int PRIO_LSB  = 8;
  localparam int PRIO_W    = 4;
  localparam int SENSE_BIT = 12;
  localparam int POL_BIT   = 13;
  localparam int ACT_BIT   = 14;
  localparam int MASK_BIT  = 15;

  // class of a source index given the class boundaries
  function automatic src_class_e class_of(int idx, int first_int, int first_spc);
    if (idx >= first_spc)      return CLS_SPECIAL;
    else if (idx >= first_int) return CLS_INTERNAL;
    else                       return CLS_NORMAL;
  endfunction

  // bits that software may change for a class
  function automatic logic [CFG_W-1:0] cfg_wmask(src_class_e cls, int vec_w);
    logic [CFG_W-1:0] m;
    m = '0;
    for (int i = 0; i < vec_w; i++) m[i] = 1'b1;
    for (int i = 0; i < PRIO_W; i++) m[PRIO_LSB+i] = 1'b1;
    m[MASK_BIT] = 1'b1;
    if (cls == CLS_NORMAL) m[SENSE_BIT] = 1'b1;
    if (cls != CLS_SPECIAL) m[POL_BIT] = 1'b1;
    return m;
  endfunction

  function automatic logic [CFG_W-1:0] cfg_store(src_class_e cls, logic [CFG_W-1:0] val,
                                                 int vec_w);
    return val & cfg_wmask(cls, vec_w);
  endfunction

  function automatic logic [CFG_W-1:0] cfg_reset(src_class_e cls, logic [CFG_W-1:0] rst,
                                                 int vec_w);
    logic [CFG_W-1:0] v;
    v = cfg_store(cls, rst, vec_w);
    if (cls == CLS_INTERNAL) v[POL_BIT] = 1'b1;
    return v;
  endfunction

  // trigger mode: 1 = level, 0 = edge
  function automatic logic trig_level(src_class_e cls, logic [CFG_W-1:0] cfg);
    case (cls)
      CLS_NORMAL:   return cfg[SENSE_BIT];
      CLS_INTERNAL: return 1'b1;
      default:      return 1'b0;
    endcase
  endfunction

  // register view with the read-only activity bit merged in
  function automatic logic [CFG_W-1:0] cfg_view(logic [CFG_W-1:0] cfg, logic pending);
    logic [CFG_W-1:0] v;
    v = cfg;
    v[ACT_BIT] = pending & ~cfg[MASK_BIT];
    return v;
  endfunction

endpackage

// File: rtl/isrc_ack_decode.sv
module isrc_ack_decode #(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  parameter int IDX_W   = 5
) (
  input  logic [NUM_CPU-1:0]         ack_valid,
  input  logic [NUM_CPU*IDX_W-1:0]   ack_idx,
  output logic [NUM_SRC-1:0]         ack_hit,
  output logic [NUM_SRC*NUM_CPU-1:0] ack_clr
);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      assign ack_clr[s*NUM_CPU+c] = ack_valid[c] &&
                                    (ack_idx[c*IDX_W +: IDX_W] == IDX_W'(s));
    end
    assign ack_hit[s] = |ack_clr[s*NUM_CPU +: NUM_CPU];
  end

endmodule

// File: rtl/isrc_cfg_slot.sv
module isrc_cfg_slot
  import isrc_pkg::*;
#(
  parameter int          SRC_IDX   = 0,
  parameter int          FIRST_INT = 16,
  parameter int          FIRST_SPC = 24,
  parameter int          FIRST_IPI = 28,
  parameter int          NUM_CPU   = 4,
  parameter int          VEC_W     = 8,
  parameter logic [31:0] RST_CFG   = 32'h0000_8000,
  parameter logic [31:0] RST_DEST  = 32'h0000_0001
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               dest_we,
  input  logic [CFG_W-1:0]   wdata,
  input  logic               ack_hit,
  input  logic [NUM_CPU-1:0] ack_clr,
  output logic [CFG_W-1:0]   cfg_q,
  output logic [NUM_CPU-1:0] dest_q,
  output logic               level,
  output logic               retrig
);

  localparam src_class_e CLS = class_of(SRC_IDX, FIRST_INT, FIRST_SPC);
  localparam logic [CFG_W-1:0] CFG_INIT = cfg_reset(CLS, RST_CFG, VEC_W);

  logic [NUM_CPU-1:0] dest_left;

  assign dest_left = dest_q & ~ack_clr;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= CFG_INIT;
    else if (cfg_we) cfg_q <= cfg_store(CLS, wdata, VEC_W);
  end

  if (SRC_IDX >= FIRST_IPI) begin : g_ipi
    always_ff @(posedge clk) begin
      if (!rst_n)       dest_q <= RST_DEST[NUM_CPU-1:0];
      else if (dest_we) dest_q <= wdata[NUM_CPU-1:0];
      else if (ack_hit) dest_q <= dest_left;
    end
    assign retrig = |dest_left;
  end else begin : g_plain
    always_ff @(posedge clk) begin
      if (!rst_n)       dest_q <= RST_DEST[NUM_CPU-1:0];
      else if (dest_we) dest_q <= wdata[NUM_CPU-1:0];
    end
    assign retrig = 1'b0;
  end

  assign level = trig_level(CLS, cfg_q);

endmodule

// File: rtl/isrc_trigger.sv
module isrc_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic irq,
  input  logic level,
  input  logic ack_hit,
  input  logic retrig,
  output logic pending,
  output logic rise
);

  logic irq_q;
  logic pend_n;

  assign rise = irq & ~irq_q;

  always_comb begin
    if (level) begin
      pend_n = irq;
    end else begin
      pend_n = pending;
      if (ack_hit) pend_n = retrig;
      if (rise)    pend_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      pending <= 1'b0;
    end else begin
      irq_q   <= irq;
      pending <= pend_n;
    end
  end

endmodule

// File: rtl/isrc_bank.sv
module isrc_bank
  import isrc_pkg::*;
#(
  parameter int          NUM_SRC   = 32,
  parameter int          NUM_CPU   = 4,
  parameter int          FIRST_INT = 16,
  parameter int          FIRST_SPC = 24,
  parameter int          FIRST_IPI = 28,
  parameter int          VEC_W     = 8,
  parameter logic [31:0] RST_CFG   = 32'h0000_8000,
  parameter logic [31:0] RST_DEST  = 32'h0000_0001,
  localparam int         IDX_W     = $clog2(NUM_SRC)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic                       reg_sel,
  input  logic [IDX_W-1:0]           reg_idx,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  input  logic [NUM_SRC-1:0]         irq_in,
  input  logic [NUM_CPU-1:0]         ack_valid,
  input  logic [NUM_CPU*IDX_W-1:0]   ack_idx,
  output logic [NUM_SRC-1:0]         pending_o,
  output logic [NUM_SRC-1:0]         level_o
);

  logic [NUM_SRC*CFG_W-1:0]   cfg_flat;
  logic [NUM_SRC*NUM_CPU-1:0] dest_flat;
  logic [NUM_SRC*NUM_CPU-1:0] ack_clr;
  logic [NUM_SRC-1:0]         ack_hit;
  logic [NUM_SRC-1:0]         cfg_we_vec;
  logic [NUM_SRC-1:0]         dest_we_vec;
  logic [NUM_SRC-1:0]         retrig_vec;
  logic [NUM_SRC-1:0]         rise_vec;

  isrc_ack_decode #(
    .NUM_SRC (NUM_SRC),
    .NUM_CPU (NUM_CPU),
    .IDX_W   (IDX_W)
  ) ack_dec_i (
    .ack_valid (ack_valid),
    .ack_idx   (ack_idx),
    .ack_hit   (ack_hit),
    .ack_clr   (ack_clr)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign cfg_we_vec[s]  = reg_wr && !reg_sel && (reg_idx == IDX_W'(s));
    assign dest_we_vec[s] = reg_wr &&  reg_sel && (reg_idx == IDX_W'(s));

    isrc_cfg_slot #(
      .SRC_IDX   (s),
      .FIRST_INT (FIRST_INT),
      .FIRST_SPC (FIRST_SPC),
      .FIRST_IPI (FIRST_IPI),
      .NUM_CPU   (NUM_CPU),
      .VEC_W     (VEC_W),
      .RST_CFG   (RST_CFG),
      .RST_DEST  (RST_DEST)
    ) slot_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_we  (cfg_we_vec[s]),
      .dest_we (dest_we_vec[s]),
      .wdata   (reg_wdata),
      .ack_hit (ack_hit[s]),
      .ack_clr (ack_clr[s*NUM_CPU +: NUM_CPU]),
      .cfg_q   (cfg_flat[s*CFG_W +: CFG_W]),
      .dest_q  (dest_flat[s*NUM_CPU +: NUM_CPU]),
      .level   (level_o[s]),
      .retrig  (retrig_vec[s])
    );

    isrc_trigger trig_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq     (irq_in[s]),
      .level   (level_o[s]),
      .ack_hit (ack_hit[s]),
      .retrig  (retrig_vec[s]),
      .pending (pending_o[s]),
      .rise    (rise_vec[s])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (reg_idx == IDX_W'(s)) begin
        if (reg_sel) reg_rdata[NUM_CPU-1:0] = dest_flat[s*NUM_CPU +: NUM_CPU];
        else         reg_rdata = cfg_view(cfg_flat[s*CFG_W +: CFG_W], pending_o[s]);
      end
    end
  end

endmodule

// File: rtl/isrc_bank_chk.sv
module isrc_bank_chk #(
  parameter int NUM_SRC   = 32,
  parameter int NUM_CPU   = 4,
  parameter int FIRST_SPC = 24,
  parameter int FIRST_IPI = 28
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_SRC*32-1:0]      cfg_flat,
  input logic [NUM_SRC*NUM_CPU-1:0] dest_flat,
  input logic [NUM_SRC-1:0]         level_o,
  input logic [NUM_SRC-1:0]         pending_o,
  input logic [NUM_SRC-1:0]         irq_in,
  input logic [NUM_SRC-1:0]         ack_hit,
  input logic [NUM_SRC*NUM_CPU-1:0] ack_clr,
  input logic [NUM_SRC-1:0]         dest_we_vec,
  input logic [NUM_SRC-1:0]         rise_vec
);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_s
    a_r8_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
      level_o[s] |=> (pending_o[s] == $past(irq_in[s])));

    a_r9_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_o[s] && pending_o[s] && !ack_hit[s]) |=> pending_o[s]);

    if (s < FIRST_IPI) begin : g_nonipi
      a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_o[s] && ack_hit[s] && !rise_vec[s]) |=> !pending_o[s]);
    end

    if (s >= FIRST_SPC) begin : g_spc
      a_r5_spc_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_flat[s*32+12] == 1'b0) && (cfg_flat[s*32+13] == 1'b0) && !level_o[s]);
    end

    if (s >= FIRST_IPI) begin : g_ipi
      a_r12_dest_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit[s] && !dest_we_vec[s]) |=>
        ((dest_flat[s*NUM_CPU +: NUM_CPU] & $past(ack_clr[s*NUM_CPU +: NUM_CPU])) == '0));
    end
  end

endmodule

bind isrc_bank isrc_bank_chk #(
  .NUM_SRC   (NUM_SRC),
  .NUM_CPU   (NUM_CPU),
  .FIRST_SPC (FIRST_SPC),
  .FIRST_IPI (FIRST_IPI)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_flat    (cfg_flat),
  .dest_flat   (dest_flat),
  .level_o     (level_o),
  .pending_o   (pending_o),
  .irq_in      (irq_in),
  .ack_hit     (ack_hit),
  .ack_clr     (ack_clr),
  .dest_we_vec (dest_we_vec),
  .rise_vec    (rise_vec)
);

// File: tb/isrc_bank_tb_top.sv
module isrc_bank_tb_top;

  localparam int NUM_SRC = 32;
  localparam int NUM_CPU = 4;
  localparam int IDX_W   = 5;

  logic                     clk = 1'b0;
  logic                     rst_n;
  logic                     reg_wr;
  logic                     reg_sel;
  logic [IDX_W-1:0]         reg_idx;
  logic [31:0]              reg_wdata;
  logic [31:0]              reg_rdata;
  logic [NUM_SRC-1:0]       irq_in;
  logic [NUM_CPU-1:0]       ack_valid;
  logic [NUM_CPU*IDX_W-1:0] ack_idx;
  logic [NUM_SRC-1:0]       pending_o;
  logic [NUM_SRC-1:0]       level_o;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  isrc_bank dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_idx   (reg_idx),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_in    (irq_in),
    .ack_valid (ack_valid),
    .ack_idx   (ack_idx),
    .pending_o (pending_o),
    .level_o   (level_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_idx = IDX_W'(idx); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, input int idx, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; reg_idx = IDX_W'(idx);
    #1 d = reg_rdata;
  endtask

  task automatic set_irq(input int idx, input logic v);
    @(negedge clk);
    irq_in[idx] = v;
    @(negedge clk);
  endtask

  task automatic ack(input int cpu, input int idx);
    @(negedge clk);
    ack_valid[cpu] = 1'b1;
    ack_idx[cpu*IDX_W +: IDX_W] = IDX_W'(idx);
    @(negedge clk);
    ack_valid[cpu] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(1'b0, 3, d);  check("R7 normal reset cfg", d, 32'h8000);
    rd(1'b0, 18, d); check("R7 internal reset cfg", d, 32'hA000);
    rd(1'b0, 26, d); check("R7 special reset cfg", d, 32'h8000);
    rd(1'b1, 29, d); check("R7 R13 reset dest", d, 32'h1);
    check("R1 reset modes 3/18/26", {29'd0, level_o[3], level_o[18], level_o[26]}, 32'b010);
    check("R7 reset pending", pending_o, 32'h0);
  endtask

  task automatic t_write_all();
    logic [31:0] d;
    wr(1'b0, 2, 32'hFFFF_FFFF);  rd(1'b0, 2, d);  check("R2 normal all ones", d, 32'hBFFF);
    check("R3 sense set gives level", 32'(level_o[2]), 32'h1);
    wr(1'b0, 17, 32'hFFFF_FFFF); rd(1'b0, 17, d); check("R4 internal all ones", d, 32'hAFFF);
    wr(1'b0, 27, 32'hFFFF_FFFF); rd(1'b0, 27, d); check("R5 special all ones", d, 32'h8FFF);
    check("R5 special stays edge", 32'(level_o[27]), 32'h0);
  endtask

  task automatic t_edge_normal();
    logic [31:0] d;
    wr(1'b0, 3, 32'h0042);
    check("R3 sense clear gives edge", 32'(level_o[3]), 32'h0);
    set_irq(3, 1'b1);
    check("R9 rise sets pending", 32'(pending_o[3]), 32'h1);
    rd(1'b0, 3, d); check("R10 activity shows pending", d, 32'h4042);
    set_irq(3, 1'b0);
    check("R9 low keeps pending", 32'(pending_o[3]), 32'h1);
    ack(0, 3);
    check("R10 ack clears pending", 32'(pending_o[3]), 32'h0);
    wr(1'b0, 3, 32'h4042); rd(1'b0, 3, d);
    check("R2 activity ignores write", d, 32'h0042);
  endtask

  task automatic t_level_normal();
    wr(1'b0, 5, 32'h1000);
    check("R3 level after write", 32'(level_o[5]), 32'h1);
    set_irq(5, 1'b1);
    check("R8 level pending high", 32'(pending_o[5]), 32'h1);
    ack(1, 5);
    check("R11 ack leaves level pending", 32'(pending_o[5]), 32'h1);
    set_irq(5, 1'b0);
    check("R8 level pending low", 32'(pending_o[5]), 32'h0);
  endtask

  task automatic t_internal();
    logic [31:0] d;
    wr(1'b0, 18, 32'h1000); rd(1'b0, 18, d);
    check("R4 internal sense reads zero", d, 32'h0000);
    check("R4 internal is level", 32'(level_o[18]), 32'h1);
    set_irq(18, 1'b1);
    check("R4 internal pending follows", 32'(pending_o[18]), 32'h1);
    set_irq(18, 1'b0);
    check("R4 internal pending drops", 32'(pending_o[18]), 32'h0);
  endtask

  task automatic t_polarity();
    logic [31:0] d;
    wr(1'b0, 6, 32'h2000); rd(1'b0, 6, d);
    check("R6 polarity stored", d, 32'h2000);
    repeat (2) @(negedge clk);
    check("R6 low input not pending", 32'(pending_o[6]), 32'h0);
    set_irq(6, 1'b1);
    check("R6 rise not inverted", 32'(pending_o[6]), 32'h1);
    ack(2, 6);
    check("R9 held high no new edge", 32'(pending_o[6]), 32'h0);
    set_irq(6, 1'b0);
  endtask

  task automatic t_special();
    logic [31:0] d;
    wr(1'b0, 25, 32'h3005); rd(1'b0, 25, d);
    check("R5 timer sense/pol zero", d, 32'h0005);
    set_irq(25, 1'b1); set_irq(25, 1'b0);
    check("R5 timer edge pending", 32'(pending_o[25]), 32'h1);
    ack(3, 25);
    check("R10 timer ack clears", 32'(pending_o[25]), 32'h0);
  endtask

  task automatic t_ipi();
    logic [31:0] d;
    wr(1'b1, 29, 32'hFFFF_FFF6); rd(1'b1, 29, d);
    check("R13 dest write", d, 32'h6);
    set_irq(29, 1'b1); set_irq(29, 1'b0);
    check("R9 ipi pending", 32'(pending_o[29]), 32'h1);
    ack(1, 29);
    rd(1'b1, 29, d); check("R12 dest bit cleared", d, 32'h4);
    check("R12 re-raised pending", 32'(pending_o[29]), 32'h1);
    ack(2, 29);
    rd(1'b1, 29, d); check("R12 dest empty", d, 32'h0);
    check("R12 last ack clears", 32'(pending_o[29]), 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_idx = '0; reg_wdata = '0;
    irq_in = '0; ack_valid = '0; ack_idx = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_all();
    t_edge_normal();
    t_level_normal();
    t_internal();
    t_polarity();
    t_special();
    t_ipi();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule